// File: doc/BRIEF.md
# Timed DDS Register Programming Sequencer

This block sits between a timed-command source and the byte-wide register port of a multi-channel direct digital synthesiser. One command either reprograms a channel's frequency and phase, runs a channel's power-up initialisation, or asks for a register read. The block expands the command into a series of single-byte register writes. Each write carries its own address, data byte and timestamp, and the writes leave on a valid/ready port.

The timestamps are planned backwards from the command's target time. Writes are spaced a fixed number of time units apart. For a program command, only the final frequency-update strobe falls on the target time itself. In tracking mode, the phase word is first corrected by a term derived from the target timestamp and the tuning word. This makes the output phase continuous with a tone that has notionally run since time zero.

When a command is accepted, the block compares the timestamp of the first write with the running time counter. If that write would already be in the past, the block refuses the command.

Top module: `dds_prog_seq`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `wr_valid`, `busy_o` and `underflow_o` are 0.
- R2: A program command (`cmd_op`=0) emits nine writes with these addresses, in this order:
  - 0x41 with the channel number;
  - 0x02;
  - 0x0a, 0x0b, 0x0c and 0x0d with the tuning word bytes, least significant first;
  - 0x0e with phase bits 7:0;
  - 0x0f with phase bits 13:8 (upper two data bits zero);
  - 0x40 with data 0.
- R3: Program writes are stamped T-40, T-35, and so on in steps of 5, so that the 0x40 strobe carries exactly T.
- R4: In a program command, the byte written to 0x02 is 0x00 when `cmd_mode`=0 (continuous) and 0x40 when `cmd_mode` is 1 (absolute) or 2 (tracking).
- R5: When `cmd_mode`=2, the phase bytes carry (pow + bits 31:18 of ((T>>3) × ftw mod 2^32)) mod 2^14. In modes 0 and 1, the phase bytes carry pow unchanged.
- R6: An initialisation command (`cmd_op`=1) emits seven writes stamped T-35 through T-5, in steps of 5:
  - 0x41 with the channel, then 0x41 with the channel OR 0x80, then 0x41 with the channel again;
  - 0x00 with 0x78;
  - 0x01, 0x02 and 0x03, each with 0x00.
- R7: A read command (`cmd_op`=2) emits one write stamped T. Its 8-bit address has bit 7 set over `cmd_reg`, and its data is 0.
- R8: A command is refused, with `underflow_o` high for one cycle after acceptance and no writes, in either of two cases:
  - its first write time is below `now_i` at acceptance;
  - T is smaller than that command's lead (40, 35 or 0).

  A first write time equal to `now_i` is accepted.
- R9: While `wr_valid` is high and `wr_ready` is low, the address, data and time outputs hold. No write is lost, repeated or reordered.
- R10: `cmd_ready` equals the negation of `busy_o`. `busy_o` rises the cycle after an accepted command and falls the cycle after the last write's handshake. `wr_valid` is high exactly while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| now_i | input | 64 | Running time counter |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken when high together with cmd_valid |
| cmd_op | input | 2 | 0 program, 1 initialise, 2 read |
| cmd_time | input | 64 | Target time T |
| cmd_chan | input | 7 | Channel number |
| cmd_ftw | input | 32 | Frequency tuning word |
| cmd_pow | input | 14 | Phase offset word |
| cmd_mode | input | 2 | 0 continuous, 1 absolute, 2 tracking |
| cmd_reg | input | 7 | Register to read (read command) |
| wr_valid | output | 1 | Register write offered |
| wr_ready | input | 1 | Register write taken |
| wr_addr | output | 8 | Write address (bit 7 marks a read request) |
| wr_data | output | 8 | Write data byte |
| wr_time | output | 64 | Write timestamp |
| busy_o | output | 1 | Sequence in progress |
| underflow_o | output | 1 | One-cycle pulse: command refused as late |

## Verification
The write port is driven straight from registered state. The first write of an accepted command is therefore visible in the cycle after the accepting edge, and `underflow_o` and `busy_o` change on that same edge. After each handshake, the next write appears one cycle later. The bench's reference model pushes the expected write list just after the accepting edge. On every falling edge, it compares the port against the head of that list and pops the head only when a handshake will occur at the next rising edge. `busy_o`, `wr_valid` and `cmd_ready` are checked against the list being non-empty on the same falling edges. This keeps every comparison one edge behind its cause, and back-pressure then shows up as the head staying put.

// File: rtl/dds_seq_pkg.sv
package dds_seq_pkg;

    localparam int TS_W   = 64;
    localparam int FTW_W  = 32;
    localparam int POW_W  = 14;
    localparam int CH_W   = 7;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int STEP_W = 4;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_INIT = 2'd1,
        OP_READ = 2'd2
    } op_e;

    localparam logic [1:0] MODE_CONT  = 2'd0;
    localparam logic [1:0] MODE_TRACK = 2'd2;

    localparam logic [ADDR_W-1:0] REG_SEL    = 8'h41;
    localparam logic [ADDR_W-1:0] REG_CFG0   = 8'h00;
    localparam logic [ADDR_W-1:0] REG_CFG1   = 8'h01;
    localparam logic [ADDR_W-1:0] REG_CLRCTL = 8'h02;
    localparam logic [ADDR_W-1:0] REG_CFG3   = 8'h03;
    localparam logic [ADDR_W-1:0] REG_FREQ0  = 8'h0a;
    localparam logic [ADDR_W-1:0] REG_PHLO   = 8'h0e;
    localparam logic [ADDR_W-1:0] REG_PHHI   = 8'h0f;
    localparam logic [ADDR_W-1:0] REG_STROBE = 8'h40;

    localparam logic [DATA_W-1:0] SEL_RESET_BIT = 8'h80;
    localparam logic [DATA_W-1:0] CFG0_VALUE    = 8'h78;
    localparam logic [DATA_W-1:0] CLR_ON_UPDATE = 8'h40;

    typedef struct packed {
        op_e              op;
        logic [CH_W-1:0]  chan;
        logic [FTW_W-1:0] ftw;
        logic [POW_W-1:0] pw;
        logic             clr;
        logic [6:0]       rreg;
    } job_t;

    function automatic logic [STEP_W-1:0] writes_of(op_e op);
        case (op)
            OP_PROG: return STEP_W'(9);
            OP_INIT: return STEP_W'(7);
            default: return STEP_W'(1);
        endcase
    endfunction

    function automatic logic [STEP_W-1:0] lead_steps(op_e op);
        case (op)
            OP_PROG: return STEP_W'(8);
            OP_INIT: return STEP_W'(7);
            default: return STEP_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/dds_phase_adj.sv
module dds_phase_adj
    import dds_seq_pkg::*;
#(
    parameter int FINE_TS = 3
) (
    input  logic [TS_W-1:0]  ts,
    input  logic [FTW_W-1:0] ftw,
    input  logic [POW_W-1:0] pw_in,
    input  logic             track,
    output logic [POW_W-1:0] pw_out
);
    logic [TS_W-1:0]  coarse;
    logic [FTW_W-1:0] prod;
    logic [POW_W-1:0] corr;

    always_comb begin
        coarse = ts >> FINE_TS;
        prod   = coarse[FTW_W-1:0] * ftw;
        corr   = prod[FTW_W-1 -: POW_W];
        pw_out = track ? POW_W'(pw_in + corr) : pw_in;
    end
endmodule

// File: rtl/dds_word_gen.sv
module dds_word_gen
    import dds_seq_pkg::*;
(
    input  job_t              job,
    input  logic [STEP_W-1:0] step,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic              last
);
    logic [1:0]        bsel;
    logic [DATA_W-1:0] chan_b;

    always_comb begin
        bsel   = 2'(step[1:0] - 2'd2);
        chan_b = DATA_W'(job.chan);
        addr   = REG_STROBE;
        data   = '0;
        last   = (step == STEP_W'(writes_of(job.op) - 1'b1));
        case (job.op)
            OP_PROG: begin
                case (step)
                    4'd0: begin addr = REG_SEL;    data = chan_b; end
                    4'd1: begin addr = REG_CLRCTL; data = job.clr ? CLR_ON_UPDATE : 8'h00; end
                    4'd2, 4'd3, 4'd4, 4'd5: begin
                        addr = REG_FREQ0 + ADDR_W'(bsel);
                        data = job.ftw[{bsel, 3'b000} +: DATA_W];
                    end
                    4'd6: begin addr = REG_PHLO; data = job.pw[7:0]; end
                    4'd7: begin addr = REG_PHHI; data = DATA_W'(job.pw >> 8) & 8'h3f; end
                    default: begin addr = REG_STROBE; data = '0; end
                endcase
            end
            OP_INIT: begin
                case (step)
                    4'd0, 4'd2: begin addr = REG_SEL; data = chan_b; end
                    4'd1: begin addr = REG_SEL; data = chan_b | SEL_RESET_BIT; end
                    4'd3: begin addr = REG_CFG0; data = CFG0_VALUE; end
                    4'd4: begin addr = REG_CFG1; data = '0; end
                    4'd5: begin addr = REG_CLRCTL; data = '0; end
                    default: begin addr = REG_CFG3; data = '0; end
                endcase
            end
            default: begin
                addr = {1'b1, job.rreg};
                data = '0;
            end
        endcase
    end
endmodule

// File: rtl/dds_seq_ctrl.sv
module dds_seq_ctrl
    import dds_seq_pkg::*;
#(
    parameter int GAP = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TS_W-1:0]   now_i,
    input  logic              cmd_valid,
    input  logic [TS_W-1:0]   cmd_time,
    input  job_t              job_in,
    input  logic              wr_ready,
    input  logic              word_last,
    output job_t              job_q,
    output logic [STEP_W-1:0] step_q,
    output logic [TS_W-1:0]   time_q,
    output logic              busy_q,
    output logic              late_q
);
    logic [TS_W-1:0] lead;
    logic [TS_W-1:0] start;
    logic            late;
    logic            accept;

    always_comb begin
        lead   = TS_W'(lead_steps(job_in.op)) * TS_W'(GAP);
        start  = cmd_time - lead;
        late   = (cmd_time < lead) || (start < now_i);
        accept = cmd_valid && !busy_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            late_q <= 1'b0;
            step_q <= '0;
            time_q <= '0;
            job_q  <= '0;
        end else begin
            late_q <= accept && late;
            if (accept && !late) begin
                busy_q <= 1'b1;
                job_q  <= job_in;
                step_q <= '0;
                time_q <= start;
            end else if (busy_q && wr_ready) begin
                if (word_last) begin
                    busy_q <= 1'b0;
                end else begin
                    step_q <= step_q + 1'b1;
                    time_q <= time_q + TS_W'(GAP);
                end
            end
        end
    end
endmodule

// File: rtl/dds_prog_seq.sv
module dds_prog_seq
    import dds_seq_pkg::*;
#(
    parameter int GAP     = 5,
    parameter int FINE_TS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TS_W-1:0]   now_i,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [TS_W-1:0]   cmd_time,
    input  logic [CH_W-1:0]   cmd_chan,
    input  logic [FTW_W-1:0]  cmd_ftw,
    input  logic [POW_W-1:0]  cmd_pow,
    input  logic [1:0]        cmd_mode,
    input  logic [6:0]        cmd_reg,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [TS_W-1:0]   wr_time,
    output logic              busy_o,
    output logic              underflow_o
);
    job_t              job_in;
    job_t              job_q;
    logic [POW_W-1:0]  pw_adj;
    logic [STEP_W-1:0] step_q;
    logic [TS_W-1:0]   time_q;
    logic              busy_q;
    logic              late_q;
    logic              word_last;

    dds_phase_adj #(.FINE_TS(FINE_TS)) u_phase (
        .ts     (cmd_time),
        .ftw    (cmd_ftw),
        .pw_in  (cmd_pow),
        .track  (cmd_mode == MODE_TRACK),
        .pw_out (pw_adj)
    );

    always_comb begin
        job_in.op   = op_e'(cmd_op);
        job_in.chan = cmd_chan;
        job_in.ftw  = cmd_ftw;
        job_in.pw   = pw_adj;
        job_in.clr  = (cmd_mode != MODE_CONT);
        job_in.rreg = cmd_reg;
    end

    dds_seq_ctrl #(.GAP(GAP)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .now_i     (now_i),
        .cmd_valid (cmd_valid),
        .cmd_time  (cmd_time),
        .job_in    (job_in),
        .wr_ready  (wr_ready),
        .word_last (word_last),
        .job_q     (job_q),
        .step_q    (step_q),
        .time_q    (time_q),
        .busy_q    (busy_q),
        .late_q    (late_q)
    );

    dds_word_gen u_words (
        .job  (job_q),
        .step (step_q),
        .addr (wr_addr),
        .data (wr_data),
        .last (word_last)
    );

    assign cmd_ready   = !busy_q;
    assign wr_valid    = busy_q;
    assign wr_time     = time_q;
    assign busy_o      = busy_q;
    assign underflow_o = late_q;
endmodule

// File: rtl/dds_prog_seq_chk.sv
module dds_prog_seq_chk
    import dds_seq_pkg::*;
#(
    parameter int GAP = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [TS_W-1:0]   wr_time,
    input logic              busy_o,
    input logic              underflow_o
);
    // R9
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_time));

    // R3
    write_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid && wr_ready |=> !wr_valid || (wr_time == $past(wr_time) + TS_W'(GAP)));

    // R2
    strobe_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid && (wr_addr == REG_STROBE) |-> wr_data == '0);

    // R7
    read_req_data_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid && wr_addr[ADDR_W-1] |-> wr_data == '0);

    // R8
    refused_idle_chk: assert property (@(posedge clk) disable iff (rst)
        underflow_o |-> !busy_o && !wr_valid);

    // R10
    accept_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready |=> busy_o != underflow_o);

    // R10
    busy_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> $past(wr_valid && wr_ready));
endmodule

bind dds_prog_seq dds_prog_seq_chk #(.GAP(GAP)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wr_time     (wr_time),
    .busy_o      (busy_o),
    .underflow_o (underflow_o)
);

// File: tb/dds_prog_seq_tb.sv
module dds_prog_seq_tb;
    localparam int CLK_P = 10;

    typedef struct {
        logic [7:0]  addr;
        logic [7:0]  data;
        logic [63:0] tm;
    } wr_t;

    logic        clk = 0;
    logic        rst = 1;
    logic [63:0] now_i = 64'd1000;
    logic        cmd_valid = 0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 0;
    logic [63:0] cmd_time = 0;
    logic [6:0]  cmd_chan = 0;
    logic [31:0] cmd_ftw = 0;
    logic [13:0] cmd_pow = 0;
    logic [1:0]  cmd_mode = 0;
    logic [6:0]  cmd_reg = 0;
    logic        wr_valid;
    logic        wr_ready = 1;
    logic [7:0]  wr_addr;
    logic [7:0]  wr_data;
    logic [63:0] wr_time;
    logic        busy_o;
    logic        underflow_o;

    int   vectors = 0;
    int   fails = 0;
    int   cycles = 0;
    int   ready_mode = 0;
    logic [7:0] lf = 8'h5a;
    wr_t  exp_q[$];

    dds_prog_seq u_dut (.*);

    always #(CLK_P/2) clk = ~clk;

    always @(negedge clk) now_i <= now_i + 1;

    always @(posedge clk) begin
        lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        cycles <= cycles + 1;
        #1;
        case (ready_mode)
            0: wr_ready = 1'b1;
            1: wr_ready = cycles[0];
            2: wr_ready = lf[2];
            default: wr_ready = (cycles % 6 == 0);
        endcase
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // reference model comparison on every cycle
    always @(negedge clk) begin
        if (!rst) begin
            chk(busy_o == (exp_q.size() != 0), "R10", "busy", 64'(busy_o), 64'(exp_q.size() != 0));
            chk(wr_valid == busy_o, "R10", "wr_valid", 64'(wr_valid), 64'(busy_o));
            chk(cmd_ready == !busy_o, "R10", "cmd_ready", 64'(cmd_ready), 64'(!busy_o));
            if (wr_valid && exp_q.size() != 0) begin
                chk(wr_addr == exp_q[0].addr, "R2", "addr", 64'(wr_addr), 64'(exp_q[0].addr));
                chk(wr_data == exp_q[0].data, "R2", "data", 64'(wr_data), 64'(exp_q[0].data));
                chk(wr_time == exp_q[0].tm, "R3", "time", wr_time, exp_q[0].tm);
                if (wr_ready) void'(exp_q.pop_front());
            end
        end
    end

    function automatic wr_t mk(input logic [7:0] a, input logic [7:0] d, input logic [63:0] t);
        wr_t w;
        w.addr = a; w.data = d; w.tm = t;
        return w;
    endfunction

    task automatic send(input logic [1:0] op, input bit rel, input logic [63:0] tv,
                        input logic [6:0] ch, input logic [31:0] ftw, input logic [13:0] pw,
                        input logic [1:0] md, input logic [6:0] rg);
        logic [63:0] t, lead, nw, sh;
        logic [31:0] prod;
        logic [13:0] pe;
        bit late;
        @(negedge clk);
        while (busy_o) @(negedge clk);
        #1;
        t = rel ? now_i + tv : tv;
        cmd_valid = 1; cmd_op = op; cmd_time = t; cmd_chan = ch;
        cmd_ftw = ftw; cmd_pow = pw; cmd_mode = md; cmd_reg = rg;
        @(posedge clk);
        nw = now_i;
        #1;
        cmd_valid = 0;
        lead = (op == 0) ? 64'd40 : (op == 1) ? 64'd35 : 64'd0;
        late = (t < lead) || (t - lead < nw);
        chk(underflow_o == late, "R8", "underflow", 64'(underflow_o), 64'(late));
        if (!late) begin
            if (op == 0) begin
                sh = t >> 3;
                prod = sh[31:0] * ftw;
                pe = (md == 2) ? 14'(pw + prod[31:18]) : pw;
                exp_q.push_back(mk(8'h41, {1'b0, ch}, t - 40));
                exp_q.push_back(mk(8'h02, (md == 0) ? 8'h00 : 8'h40, t - 35)); // R4
                for (int i = 0; i < 4; i++)
                    exp_q.push_back(mk(8'h0a + 8'(i), ftw[8*i +: 8], t - 30 + 64'(5*i)));
                exp_q.push_back(mk(8'h0e, pe[7:0], t - 10));            // R5
                exp_q.push_back(mk(8'h0f, {2'b00, pe[13:8]}, t - 5));  // R5
                exp_q.push_back(mk(8'h40, 8'h00, t));                   // R3
            end else if (op == 1) begin
                exp_q.push_back(mk(8'h41, {1'b0, ch}, t - 35));         // R6
                exp_q.push_back(mk(8'h41, {1'b1, ch}, t - 30));
                exp_q.push_back(mk(8'h41, {1'b0, ch}, t - 25));
                exp_q.push_back(mk(8'h00, 8'h78, t - 20));
                exp_q.push_back(mk(8'h01, 8'h00, t - 15));
                exp_q.push_back(mk(8'h02, 8'h00, t - 10));
                exp_q.push_back(mk(8'h03, 8'h00, t - 5));
            end else begin
                exp_q.push_back(mk({1'b1, rg}, 8'h00, t));              // R7
            end
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || busy_o) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(cmd_ready == 1, "R1", "cmd_ready", 64'(cmd_ready), 64'd1);
        chk(wr_valid == 0, "R1", "wr_valid", 64'(wr_valid), 64'd0);
        chk(busy_o == 0, "R1", "busy", 64'(busy_o), 64'd0);
        chk(underflow_o == 0, "R1", "underflow", 64'(underflow_o), 64'd0);

        // R2 R3 R4 continuous program, full ready
        ready_mode = 0;
        send(2'd0, 1, 64'd100, 7'd3, 32'h1234_5678, 14'h2abc, 2'd0, 7'd0);
        drain();
        // R4 absolute, alternating ready
        ready_mode = 1;
        send(2'd0, 1, 64'd200, 7'd1, 32'hcafe_f00d, 14'h0155, 2'd1, 7'd0);
        drain();
        // R5 tracking with wrap, irregular ready
        ready_mode = 2;
        send(2'd0, 0, 64'h0000_1234_5678_9000, 7'd2, 32'hdead_beef, 14'h3ff0, 2'd2, 7'd0);
        drain();
        send(2'd0, 1, 64'd5000, 7'd6, 32'h8000_0001, 14'h0001, 2'd2, 7'd0);
        drain();
        // R6 initialisation, first write exactly at now (R8 boundary accepted)
        ready_mode = 0;
        send(2'd1, 1, 64'd35, 7'd5, 32'h0, 14'h0, 2'd0, 7'd0);
        drain();
        // R7 read request
        send(2'd2, 1, 64'd3, 7'd0, 32'h0, 14'h0, 2'd0, 7'h0e);
        drain();
        // R8 program at exact boundary, then one unit late
        send(2'd0, 1, 64'd40, 7'd4, 32'h0f0f_0f0f, 14'h1111, 2'd0, 7'd0);
        drain();
        send(2'd0, 1, 64'd39, 7'd4, 32'h0f0f_0f0f, 14'h1111, 2'd0, 7'd0);
        drain();
        send(2'd1, 1, 64'd34, 7'd4, 32'h0, 14'h0, 2'd0, 7'd0);
        drain();
        send(2'd0, 0, 64'd20, 7'd4, 32'h1, 14'h1, 2'd0, 7'd0);
        drain();
        send(2'd2, 0, 64'd5, 7'd0, 32'h0, 14'h0, 2'd0, 7'h02);
        drain();
        // R9 long stalls on every write
        ready_mode = 3;
        send(2'd0, 1, 64'd900, 7'd7, 32'h0bad_cafe, 14'h2001, 2'd2, 7'd0);
        drain();
        send(2'd1, 1, 64'd900, 7'd127, 32'h0, 14'h0, 2'd0, 7'd0);
        drain();
        ready_mode = 0;
        repeat (4) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule